// File: doc/BRIEF.md
# Scripted Power Sequencer Engine

This block runs short power-management scripts kept in a small instruction memory. Each instruction is four bytes wide. It carries a 16-bit message that is broadcast to the regulators, a delay, and the index of the instruction that follows. When an event arrives (warm reset, entry into sleep, or wake-up of either of two supply groups), the engine looks up that event's start index. It then walks the linked list, emitting one message per step and waiting out each step's delay. The walk ends when it meets the terminator index.

A host configures the block through eight byte registers. Script bytes are written indirectly: the host first writes a byte address, then writes the data byte. Every register except the key register is write-protected until a two-value key sequence has been written. A delay counts strobes of an external timebase. Events that arrive while a script is running are queued, and they start in priority order once the engine is free.

Top module: `pwr_script_seq`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 key, 1 memory byte address, 2 memory data, 3 sleep start index, 4 group-A wake start index, 5 group-B wake start index, 6 warm-reset start index, 7 event register.
- R2: Writing 0xC3 and then 0xC3's partner 0x3C to the key register opens the lock. Any other value, including 0, locks it again. Reading the key register returns 1 when open and 0 otherwise. After reset the block is locked.
- R3: While locked, writes to offsets 1 to 7 are ignored. Reads still return the stored contents.
- R4: A write to offset 2 stores the byte at the memory address held in offset 1. A read of offset 2 returns that byte. The address register never auto-increments.
- R5: Instruction i occupies bytes 4i to 4i+3, holding in turn the message high byte, the message low byte, the delay and the next index.
- R6: Start registers reset to 0x3F. An event whose start index is 0x3F runs nothing, and `busy` stays low.
- R7: Each step drives `msg_data` with `msg_valid` high for one cycle. `busy` is high from the first message until the step whose next index is 0x3F or above has completed.
- R8: A step with delay d>0 waits d cycles in which `tick` is high before the next message. With `tick` held high, consecutive messages are d+1 cycles apart. A delay of 0 gives the next message on the following cycle. While `tick` is low the engine holds.
- R9: Events arriving while busy are held pending and start once the engine is idle, in the order warm reset, sleep, group-A wake, group-B wake.
- R10: In the event register, writing 1 to bit 0 requests the sleep script (the bit reads back 0). Bit 3 enables the two wake events and bit 4 enables warm reset. An event that arrives while its enable is clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| trig_warm | input | 1 | Warm-reset event pulse |
| trig_sleep | input | 1 | Active-to-sleep event pulse |
| trig_wake_a | input | 1 | Group-A wake event pulse |
| trig_wake_b | input | 1 | Group-B wake event pulse |
| tick | input | 1 | Timebase strobe for delays |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_data | output | 16 | Broadcast message |
| busy | output | 1 | A script is running |

## Verification
The memory port is swept across all 256 byte addresses with an arithmetic pattern, which separates address decode errors from data path errors. A six-step chain with delays 0 to 5 and the tick held high turns each message spacing into an exact d+1 value, so off-by-one faults in the delay counter show up. Stalling the tick, then firing three events at once during a run, exposes both the hold behaviour and the service order. Key sequences given in the wrong order, locked writes, disabled events and a start index of 0x3F all check that stimulus with no effect leaves the observable registers and message stream unchanged.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        RA_KEY   = 3'd0,
        RA_MADDR = 3'd1,
        RA_MDATA = 3'd2,
        RA_SLP   = 3'd3,
        RA_WKA   = 3'd4,
        RA_WKB   = 3'd5,
        RA_WARM  = 3'd6,
        RA_EVT   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_WAIT} eng_state_e;
    typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} key_state_e;

    // event sources, lower index wins
    localparam int NSRC     = 4;
    localparam int SRC_WARM = 0;
    localparam int SRC_SLP  = 1;
    localparam int SRC_WKA  = 2;
    localparam int SRC_WKB  = 3;

    localparam int EVT_OFF_BIT  = 0;
    localparam int EVT_WAKE_BIT = 3;
    localparam int EVT_WARM_BIT = 4;

    typedef struct packed {
        logic [15:0] msg;
        logic [7:0]  dly;
        logic [7:0]  nxt;
    } ins_t;

    function automatic reg_addr_e src_addr(input int i);
        case (i)
            SRC_WARM: return RA_WARM;
            SRC_SLP:  return RA_SLP;
            SRC_WKA:  return RA_WKA;
            default:  return RA_WKB;
        endcase
    endfunction

endpackage

// File: rtl/pss_regs.sv
module pss_regs
    import pss_pkg::*;
#(
    parameter int         IDX_W = 6,
    parameter logic [7:0] KEY_A = 8'hC3,
    parameter logic [7:0] KEY_B = 8'h3C
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic [2:0]                     addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    input  logic [IDX_W-1:0]               fetch_idx,
    output ins_t                           fetch_ins,
    output logic [NSRC-1:0][IDX_W-1:0]     starts,
    output logic                           wake_en,
    output logic                           warm_en,
    output logic                           devoff_req,
    output logic                           unlocked
);
    localparam int              ADDR_W  = IDX_W + 2;
    localparam int              DEPTH   = 1 << ADDR_W;
    localparam logic [IDX_W-1:0] END_IDX = '1;

    key_state_e        ks;
    logic [ADDR_W-1:0] maddr;
    logic [7:0]        mem [DEPTH];
    logic              prot_wr;
    logic [NSRC-1:0]   hit;

    assign unlocked   = (ks == LK_OPEN);
    assign prot_wr    = wr && unlocked;
    assign devoff_req = prot_wr && (addr == RA_EVT) && wdata[EVT_OFF_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ks <= LK_SHUT;
        end else if (wr && addr == RA_KEY) begin
            if (wdata == KEY_A)
                ks <= LK_HALF;
            else if (ks == LK_HALF && wdata == KEY_B)
                ks <= LK_OPEN;
            else
                ks <= LK_SHUT;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_hit
        assign hit[g] = prot_wr && (addr == src_addr(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            maddr   <= '0;
            wake_en <= 1'b0;
            warm_en <= 1'b0;
            for (int i = 0; i < NSRC; i++) starts[i] <= END_IDX;
        end else begin
            if (prot_wr && addr == RA_MADDR) maddr <= wdata[ADDR_W-1:0];
            if (prot_wr && addr == RA_EVT) begin
                wake_en <= wdata[EVT_WAKE_BIT];
                warm_en <= wdata[EVT_WARM_BIT];
            end
            for (int i = 0; i < NSRC; i++)
                if (hit[i]) starts[i] <= wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (prot_wr && addr == RA_MDATA) mem[maddr] <= wdata;
    end

    always_comb begin
        fetch_ins.msg = {mem[{fetch_idx, 2'd0}], mem[{fetch_idx, 2'd1}]};
        fetch_ins.dly = mem[{fetch_idx, 2'd2}];
        fetch_ins.nxt = mem[{fetch_idx, 2'd3}];
    end

    always_comb begin
        case (addr)
            RA_KEY:   rdata = {7'd0, unlocked};
            RA_MADDR: rdata = 8'(maddr);
            RA_MDATA: rdata = mem[maddr];
            RA_SLP:   rdata = 8'(starts[SRC_SLP]);
            RA_WKA:   rdata = 8'(starts[SRC_WKA]);
            RA_WKB:   rdata = 8'(starts[SRC_WKB]);
            RA_WARM:  rdata = 8'(starts[SRC_WARM]);
            default:  rdata = {3'd0, warm_en, wake_en, 3'd0};
        endcase
    end

endmodule

// File: rtl/pss_arb.sv
module pss_arb
    import pss_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic            take,
    output logic [NSRC-1:0] pick,
    output logic            any
);
    logic [NSRC-1:0] pend;

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst) pend[g] <= 1'b0;
            else     pend[g] <= req[g] | (pend[g] & ~(take & pick[g]));
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/pss_engine.sv
module pss_engine
    import pss_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             tick,
    input  ins_t             ins,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             msg_valid,
    output logic [15:0]      msg,
    output logic             busy,
    output logic             idle
);
    localparam logic [IDX_W-1:0] END_IDX = '1;

    eng_state_e       st;
    logic [IDX_W-1:0] ptr;
    logic [7:0]       cnt;
    logic             last;

    // an index at or above the terminator ends the walk
    assign last = (ins.nxt >= 8'(END_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ptr <= END_IDX;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go && start_idx != END_IDX) begin
                    ptr <= start_idx;
                    st  <= ST_EMIT;
                end
                ST_EMIT: if (ins.dly == 8'd0) begin
                    if (last) st  <= ST_IDLE;
                    else      ptr <= ins.nxt[IDX_W-1:0];
                end else begin
                    cnt <= ins.dly;
                    st  <= ST_WAIT;
                end
                ST_WAIT: if (tick) begin
                    if (cnt == 8'd1) begin
                        if (last) st <= ST_IDLE;
                        else begin
                            ptr <= ins.nxt[IDX_W-1:0];
                            st  <= ST_EMIT;
                        end
                    end else begin
                        cnt <= cnt - 8'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign fetch_idx = ptr;
    assign msg_valid = (st == ST_EMIT);
    assign msg       = ins.msg;
    assign busy      = (st != ST_IDLE);
    assign idle      = (st == ST_IDLE);

endmodule

// File: rtl/pwr_script_seq.sv
module pwr_script_seq
    import pss_pkg::*;
#(
    parameter int         IDX_W = 6,
    parameter logic [7:0] KEY_A = 8'hC3,
    parameter logic [7:0] KEY_B = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        trig_warm,
    input  logic        trig_sleep,
    input  logic        trig_wake_a,
    input  logic        trig_wake_b,
    input  logic        tick,
    output logic        msg_valid,
    output logic [15:0] msg_data,
    output logic        busy
);
    localparam logic [IDX_W-1:0] END_IDX = '1;

    ins_t                       ins;
    logic [IDX_W-1:0]           fetch_idx;
    logic [NSRC-1:0][IDX_W-1:0] starts;
    logic                       wake_en, warm_en, devoff_req, unlocked;
    logic [NSRC-1:0]            req, pick;
    logic                       any, idle;
    logic [IDX_W-1:0]           start_sel;

    pss_regs #(.IDX_W(IDX_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .fetch_idx(fetch_idx), .fetch_ins(ins), .starts(starts),
        .wake_en(wake_en), .warm_en(warm_en), .devoff_req(devoff_req), .unlocked(unlocked)
    );

    always_comb begin
        req[SRC_WARM] = trig_warm & warm_en;
        req[SRC_SLP]  = trig_sleep | devoff_req;
        req[SRC_WKA]  = trig_wake_a & wake_en;
        req[SRC_WKB]  = trig_wake_b & wake_en;
    end

    pss_arb u_arb (
        .clk(clk), .rst(rst), .req(req), .take(idle), .pick(pick), .any(any)
    );

    always_comb begin
        start_sel = END_IDX;
        for (int i = 0; i < NSRC; i++)
            if (pick[i]) start_sel = starts[i];
    end

    pss_engine #(.IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst(rst), .go(any), .start_idx(start_sel), .tick(tick), .ins(ins),
        .fetch_idx(fetch_idx), .msg_valid(msg_valid), .msg(msg_data), .busy(busy), .idle(idle)
    );

endmodule

// File: rtl/pss_chk.sv
module pss_chk
    import pss_pkg::*;
#(
    parameter int         IDX_W = 6,
    parameter logic [7:0] KEY_B = 8'h3C
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr,
    input logic [2:0]                 reg_addr,
    input logic [7:0]                 reg_wdata,
    input logic                       unlocked,
    input logic [NSRC-1:0][IDX_W-1:0] starts,
    input logic                       msg_valid,
    input logic                       busy,
    input logic                       tick,
    input logic [NSRC-1:0]            pick
);
    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata == KEY_B));

    a_r3_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !unlocked && reg_addr != 3'd0) |=> $stable(starts));

    a_r7_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> busy);

    a_r7_first_emit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> msg_valid);

    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !msg_valid && !tick) |=> (busy && !msg_valid));

    a_r9_one_pick: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick));

endmodule

bind pwr_script_seq pss_chk #(.IDX_W(IDX_W), .KEY_B(KEY_B)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .unlocked(unlocked), .starts(starts), .msg_valid(msg_valid), .busy(busy),
    .tick(tick), .pick(pick)
);

// File: tb/sim_pwr_script_seq.sv
module sim_pwr_script_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        trig_warm = 1'b0, trig_sleep = 1'b0, trig_wake_a = 1'b0, trig_wake_b = 1'b0;
    logic        tick = 1'b1;
    logic        msg_valid;
    logic [15:0] msg_data;
    logic        busy;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nlog = 0;
    logic [15:0] lmsg [256];
    int          lcyc [256];

    always #2 clk = ~clk;

    pwr_script_seq u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_warm(trig_warm), .trig_sleep(trig_sleep),
        .trig_wake_a(trig_wake_a), .trig_wake_b(trig_wake_b), .tick(tick),
        .msg_valid(msg_valid), .msg_data(msg_data), .busy(busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && msg_valid && nlog < 256) begin
            lmsg[nlog] = msg_data;
            lcyc[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_ins(input int idx, input logic [15:0] m, input logic [7:0] dl, input logic [7:0] nx);
        wr(3'd1, 8'(idx * 4));     wr(3'd2, m[15:8]);
        wr(3'd1, 8'(idx * 4 + 1)); wr(3'd2, m[7:0]);
        wr(3'd1, 8'(idx * 4 + 2)); wr(3'd2, dl);
        wr(3'd1, 8'(idx * 4 + 3)); wr(3'd2, nx);
    endtask

    function automatic logic [7:0] pat(input int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    function automatic logic [15:0] chain_msg(input int i);
        return 16'(16'h1000 + i * 16'h0111);
    endfunction

    initial begin
        #(4 * 100000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state (R2, R6, R1)
        rd(3'd0, d); check("R2 key after reset", d, 8'h00);
        rd(3'd3, d); check("R6 sleep start reset", d, 8'h3F);
        rd(3'd4, d); check("R6 wakeA start reset", d, 8'h3F);
        rd(3'd5, d); check("R6 wakeB start reset", d, 8'h3F);
        rd(3'd6, d); check("R6 warm start reset", d, 8'h3F);
        rd(3'd7, d); check("R1 event reg reset", d, 8'h00);
        check("R7 busy after reset", busy, 1'b0);

        // locked writes ignored (R3)
        wr(3'd3, 8'h05); rd(3'd3, d); check("R3 locked start write", d, 8'h3F);
        wr(3'd1, 8'h10); rd(3'd1, d); check("R3 locked addr write", d, 8'h00);

        // key order (R2)
        wr(3'd0, 8'h3C); wr(3'd0, 8'hC3); rd(3'd0, d); check("R2 reversed key", d, 8'h00);
        wr(3'd0, 8'h11); wr(3'd0, 8'h3C); rd(3'd0, d); check("R2 broken key", d, 8'h00);
        wr(3'd0, 8'hC3); wr(3'd0, 8'h3C); rd(3'd0, d); check("R2 key open", d, 8'h01);

        // full memory sweep (R4)
        for (int b = 0; b < 256; b++) begin
            wr(3'd1, 8'(b)); wr(3'd2, pat(b));
        end
        for (int b = 0; b < 256; b++) begin
            wr(3'd1, 8'(b)); rd(3'd2, d); check("R4 memory byte", d, pat(b));
        end
        wr(3'd1, 8'd20); wr(3'd2, 8'h11); wr(3'd2, 8'h22);
        rd(3'd2, d); check("R4 no auto increment data", d, 8'h22);
        rd(3'd1, d); check("R4 address unchanged", d, 8'd20);
        wr(3'd1, 8'd21); rd(3'd2, d); check("R4 neighbour untouched", d, pat(21));

        // delay chain with tick held high (R5, R7, R8)
        for (int i = 0; i < 6; i++)
            load_ins(10 + i, chain_msg(i), 8'(i), (i == 5) ? 8'h3F : 8'(11 + i));
        wr(3'd3, 8'd10);
        base = nlog;
        @(negedge clk); trig_sleep = 1'b1; @(negedge clk); trig_sleep = 1'b0;
        repeat (60) @(negedge clk);
        check("R7 chain message count", nlog - base, 6);
        for (int i = 0; i < 6; i++) check("R5 chain message", lmsg[base + i], chain_msg(i));
        for (int i = 0; i < 5; i++) check("R8 spacing d+1", lcyc[base + i + 1] - lcyc[base + i], i + 1);
        check("R7 busy after end", busy, 1'b0);

        // tick freeze, wake enable (R8, R10)
        load_ins(20, 16'hBEEF, 8'd3, 8'd21);
        load_ins(21, 16'hCAFE, 8'd0, 8'h7F);
        wr(3'd4, 8'd20); wr(3'd7, 8'h08);
        tick = 1'b0;
        base = nlog;
        @(negedge clk); trig_wake_a = 1'b1; @(negedge clk); trig_wake_a = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 frozen count", nlog - base, 1);
        check("R8 frozen busy", busy, 1'b1);
        tick = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 resumed count", nlog - base, 2);
        check("R5 second message", lmsg[base + 1], 16'hCAFE);
        check("R7 end on index above 0x3F", busy, 1'b0);

        // start index 0x3F (R6)
        base = nlog;
        @(negedge clk); trig_wake_b = 1'b1; @(negedge clk); trig_wake_b = 1'b0;
        repeat (10) begin
            @(negedge clk);
            check("R6 no run busy", busy, 1'b0);
        end
        check("R6 no messages", nlog - base, 0);

        // warm enable gating (R10)
        load_ins(30, 16'h5A5A, 8'd1, 8'h3F);
        wr(3'd6, 8'd30);
        base = nlog;
        @(negedge clk); trig_warm = 1'b1; @(negedge clk); trig_warm = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 warm disabled", nlog - base, 0);
        wr(3'd7, 8'h18);
        repeat (10) @(negedge clk);
        check("R10 dropped not pending", nlog - base, 0);
        @(negedge clk); trig_warm = 1'b1; @(negedge clk); trig_warm = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 warm enabled count", nlog - base, 1);
        check("R10 warm message", lmsg[base], 16'h5A5A);

        // pending and priority (R9)
        load_ins(31, 16'h3333, 8'd0, 8'h3F);
        wr(3'd5, 8'd31);
        tick = 1'b0;
        base = nlog;
        @(negedge clk); trig_sleep = 1'b1; @(negedge clk); trig_sleep = 1'b0;
        repeat (5) @(negedge clk);
        trig_wake_b = 1'b1; trig_wake_a = 1'b1; trig_warm = 1'b1;
        @(negedge clk);
        trig_wake_b = 1'b0; trig_wake_a = 1'b0; trig_warm = 1'b0;
        repeat (5) @(negedge clk);
        tick = 1'b1;
        repeat (200) @(negedge clk);
        check("R9 total count", nlog - base, 10);
        for (int i = 0; i < 6; i++) check("R9 running script first", lmsg[base + i], chain_msg(i));
        check("R9 warm next", lmsg[base + 6], 16'h5A5A);
        check("R9 wakeA next", lmsg[base + 7], 16'hBEEF);
        check("R9 wakeA tail", lmsg[base + 8], 16'hCAFE);
        check("R9 wakeB last", lmsg[base + 9], 16'h3333);

        // device-off request (R10)
        base = nlog;
        wr(3'd7, 8'h19);
        rd(3'd7, d); check("R10 off bit reads zero", d, 8'h18);
        repeat (60) @(negedge clk);
        check("R10 off runs sleep script", nlog - base, 6);
        check("R10 off first message", lmsg[base], 16'h1000);

        // relock (R2, R3)
        wr(3'd0, 8'h00); rd(3'd0, d); check("R2 relock", d, 8'h00);
        wr(3'd3, 8'h05); rd(3'd3, d); check("R3 write after relock", d, 8'd10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule